// File: doc/BRIEF.md
# Saturating Integer Divide Unit

This block is a multi-cycle 32-bit integer divider for the execute stage of a processor. A one-cycle start strobe hands it a dividend, a divisor and an 8-bit operation code that selects signed or unsigned division. It returns a 64-bit pair with the quotient in the low word and the remainder in the high word. It also returns three status flags and a one-cycle completion strobe.

The unit never traps. A zero divisor, and the signed case of the most negative value divided by minus one, each give a fixed saturated quotient with a zero remainder. Both raise the overflow flag and feed a sticky overflow flag. Internally, a radix-2 restoring divider works on operand magnitudes, and a final cycle applies the signs and the saturation rules. Every accepted operation takes the same number of cycles.

Top module: `sat_divider`

## Requirements
- R1: An operation code of 0x20 selects signed division and 0x21 selects unsigned division. A start strobe that carries any other code is ignored: busy stays low and no completion strobe follows.
- R2: The result places the quotient in bits 31:0 and the remainder in bits 63:32.
- R3: Signed division truncates the quotient toward zero, and a nonzero remainder carries the sign of the dividend.
- R4: Unsigned division returns the exact unsigned quotient and remainder for any nonzero divisor.
- R5: In signed mode with a zero divisor, the quotient is 0x7FFFFFFF for a non-negative dividend and 0x80000000 for a negative one. The remainder is 0.
- R6: In unsigned mode with a zero divisor, the quotient is 0xFFFFFFFF and the remainder is 0.
- R7: In signed mode, 0x80000000 divided by 0xFFFFFFFF gives quotient 0x7FFFFFFF and remainder 0.
- R8: The overflow flag is set at completion of a saturating case (R5, R6, R7) and cleared at completion of every other division. It changes only on a completion cycle.
- R9: The sticky overflow flag ORs in each new overflow value and only reset clears it.
- R10: The advance-overflow flag reads 0 after every completed division.
- R11: The completion strobe rises exactly 34 clock cycles after the edge that accepts a start, and lasts one cycle. Busy is high from the cycle after acceptance until completion.
- R12: A start strobe that arrives while the unit is busy is ignored. The result belongs to the accepted operands, and no extra completion follows.
- R13: After reset, busy, done, all flags and the result are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a division |
| opcode_i | input | 8 | Operation code: 0x20 signed, 0x21 unsigned |
| dividend_i | input | 32 | Dividend, sampled with start |
| divisor_i | input | 32 | Divisor, sampled with start |
| busy_o | output | 1 | High while an operation is in progress |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | 64 | {remainder, quotient} |
| ovf_o | output | 1 | Overflow flag of the last division |
| sticky_ovf_o | output | 1 | Sticky overflow flag |
| adv_ovf_o | output | 1 | Advance-overflow flag, cleared by a division |

## Verification
The assertions assume that start is a registered strobe held stable around the clock edge. They also assume that the operands only matter on the edge that accepts a start, so they watch the flags and the strobes rather than the operand inputs. The stimulus drives every input on the falling edge and keeps start high for one cycle. It changes the operands freely while the unit is busy, and once on purpose raises start in mid-operation. Random operands are biased toward a zero divisor, minus one and the most negative dividend, so that each saturating path appears many times.

// File: rtl/sdiv_pkg.sv
// Package: shared constants and the controller state type for the
// saturating divider. Assumes a 32-bit machine word by default.
package sdiv_pkg;
    localparam int unsigned XLEN   = 32;
    localparam int unsigned OPC_W  = 8;
    localparam logic [OPC_W-1:0] OPC_DIV_SIGNED   = 8'h20;
    localparam logic [OPC_W-1:0] OPC_DIV_UNSIGNED = 8'h21;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_ITER  = 2'd2,
        ST_FIX   = 2'd3
    } sdiv_state_e;
endpackage

// File: rtl/sdiv_ctrl.sv
// Module: sdiv_ctrl
// Sequences one division: one setup cycle, W iteration cycles and one
// fixup cycle. It assumes go_i is only meaningful when a valid operation
// code is present. Requests seen outside the idle state are dropped.
module sdiv_ctrl #(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic accept_o,
    output logic load_o,
    output logic step_o,
    output logic fix_o,
    output logic busy_o
);
    import sdiv_pkg::*;

    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    sdiv_state_e  state_q;
    logic [CW-1:0] cnt_q;

    assign accept_o = go_i && (state_q == ST_IDLE);
    assign load_o   = (state_q == ST_SETUP);
    assign step_o   = (state_q == ST_ITER);
    assign fix_o    = (state_q == ST_FIX);
    assign busy_o   = (state_q != ST_IDLE);

    // Purpose: advance the state machine and the iteration counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (go_i) state_q <= ST_SETUP;
                end
                ST_SETUP: begin
                    state_q <= ST_ITER;
                    cnt_q   <= '0;
                end
                ST_ITER: begin
                    if (cnt_q == LAST) state_q <= ST_FIX;
                    else               cnt_q   <= cnt_q + 1'b1;
                end
                ST_FIX: begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> (busy_o && load_o)); // R11
    AST_FIX_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && cnt_q == LAST) |=> fix_o); // R11
    AST_SETUP_THEN_ITER: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> (step_o && cnt_q == '0)); // R11
    AST_BUSY_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && go_i && !fix_o) |=> busy_o); // R12
endmodule

// File: rtl/sdiv_core.sv
// Module: sdiv_core
// Radix-2 restoring divider on unsigned magnitudes. load_i captures the
// operands and each step_i cycle produces one quotient bit, MSB first.
// It assumes the caller issues exactly W steps after a load. A zero
// divisor yields meaningless bits, which the fixup stage replaces.
module sdiv_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         step_i,
    input  logic [W-1:0] dvd_mag_i,
    input  logic [W-1:0] dvs_mag_i,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);
    logic [W-1:0] rem_q, quo_q, dvs_q;
    logic [W:0]   shifted, trial;
    logic         fits;

    // Purpose: form the shifted partial remainder and the trial subtraction.
    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        trial   = shifted - {1'b0, dvs_q};
        fits    = !trial[W];
    end

    // Purpose: load the operands or retire one quotient bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
        end else if (load_i) begin
            rem_q <= '0;
            quo_q <= dvd_mag_i;
            dvs_q <= dvs_mag_i;
        end else if (step_i) begin
            rem_q <= fits ? trial[W-1:0] : shifted[W-1:0];
            quo_q <= {quo_q[W-2:0], fits};
        end
    end

    assign quo_o = quo_q;
    assign rem_o = rem_q;

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        (dvs_q != '0) |-> (rem_q < dvs_q)); // R4
    AST_LOAD_CLEARS_REM: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (rem_q == '0)); // R4
endmodule

// File: rtl/sdiv_fixup.sv
// Module: sdiv_fixup
// Combinational end stage. It applies signs to the magnitude quotient and
// remainder and substitutes the saturated values for a zero divisor and
// for signed MIN / -1. It assumes the magnitudes come from the raw
// operands that are presented alongside them.
module sdiv_fixup #(
    parameter int W = 32
) (
    input  logic         signed_i,
    input  logic [W-1:0] dvd_i,
    input  logic [W-1:0] dvs_i,
    input  logic [W-1:0] mag_quo_i,
    input  logic [W-1:0] mag_rem_i,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o,
    output logic         ovf_o
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    logic neg_dvd, neg_dvs, zero_dvs, min_by_m1;

    // Purpose: classify the operands for sign handling and saturation.
    always_comb begin
        neg_dvd   = signed_i && dvd_i[W-1];
        neg_dvs   = signed_i && dvs_i[W-1];
        zero_dvs  = (dvs_i == '0);
        min_by_m1 = signed_i && (dvd_i == MOST_NEG) && (dvs_i == ALL_ONES);
    end

    // Purpose: choose saturated or sign-corrected quotient and remainder.
    always_comb begin
        if (zero_dvs) begin
            ovf_o = 1'b1;
            rem_o = '0;
            if (!signed_i)    quo_o = ALL_ONES;
            else if (neg_dvd) quo_o = MOST_NEG;
            else              quo_o = MOST_POS;
        end else if (min_by_m1) begin
            ovf_o = 1'b1;
            rem_o = '0;
            quo_o = MOST_POS;
        end else begin
            ovf_o = 1'b0;
            quo_o = (neg_dvd ^ neg_dvs) ? (~mag_quo_i + 1'b1) : mag_quo_i;
            rem_o = neg_dvd ? (~mag_rem_i + 1'b1) : mag_rem_i;
        end
    end
endmodule

// File: rtl/sat_divider.sv
// Module: sat_divider (top)
// Saturating signed/unsigned divider. It captures the operands on an
// accepted start, runs the restoring core, then registers
// {remainder, quotient}, the overflow flags and a one-cycle done strobe.
// It assumes start_i is a clean one-cycle strobe from registered logic.
module sat_divider #(
    parameter int W = sdiv_pkg::XLEN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [7:0]       opcode_i,
    input  logic [W-1:0]     dividend_i,
    input  logic [W-1:0]     divisor_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [2*W-1:0]   result_o,
    output logic             ovf_o,
    output logic             sticky_ovf_o,
    output logic             adv_ovf_o
);
    import sdiv_pkg::*;

    logic           opc_signed, opc_valid, go, accept, load, step, fix, busy;
    logic           sgn_q;
    logic [W-1:0]   dvd_q, dvs_q;
    logic [W-1:0]   dvd_mag, dvs_mag, core_quo, core_rem;
    logic [W-1:0]   fx_quo, fx_rem;
    logic           fx_ovf;
    logic [2*W-1:0] result_q;
    logic           done_q, ovf_q, sticky_q, adv_q;

    // Purpose: decode the operation code into a request and a sign mode.
    always_comb begin
        opc_signed = (opcode_i == OPC_DIV_SIGNED);
        opc_valid  = opc_signed || (opcode_i == OPC_DIV_UNSIGNED);
        go         = start_i && opc_valid;
    end

    sdiv_ctrl #(.W(W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_i     (go),
        .accept_o (accept),
        .load_o   (load),
        .step_o   (step),
        .fix_o    (fix),
        .busy_o   (busy)
    );

    // Purpose: hold the accepted operands and mode for the whole operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sgn_q <= 1'b0;
            dvd_q <= '0;
            dvs_q <= '0;
        end else if (accept) begin
            sgn_q <= opc_signed;
            dvd_q <= dividend_i;
            dvs_q <= divisor_i;
        end
    end

    // Purpose: form operand magnitudes for the unsigned core.
    always_comb begin
        dvd_mag = (sgn_q && dvd_q[W-1]) ? (~dvd_q + 1'b1) : dvd_q;
        dvs_mag = (sgn_q && dvs_q[W-1]) ? (~dvs_q + 1'b1) : dvs_q;
    end

    sdiv_core #(.W(W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .step_i    (step),
        .dvd_mag_i (dvd_mag),
        .dvs_mag_i (dvs_mag),
        .quo_o     (core_quo),
        .rem_o     (core_rem)
    );

    sdiv_fixup #(.W(W)) u_fix (
        .signed_i  (sgn_q),
        .dvd_i     (dvd_q),
        .dvs_i     (dvs_q),
        .mag_quo_i (core_quo),
        .mag_rem_i (core_rem),
        .quo_o     (fx_quo),
        .rem_o     (fx_rem),
        .ovf_o     (fx_ovf)
    );

    // Purpose: register the result pair, the flags and the done strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            done_q   <= 1'b0;
            ovf_q    <= 1'b0;
            sticky_q <= 1'b0;
            adv_q    <= 1'b0;
        end else begin
            done_q <= fix;
            if (fix) begin
                result_q <= {fx_rem, fx_quo};
                ovf_q    <= fx_ovf;
                sticky_q <= sticky_q | fx_ovf;
                adv_q    <= 1'b0;
            end
        end
    end

    assign busy_o       = busy;
    assign done_o       = done_q;
    assign result_o     = result_q;
    assign ovf_o        = ovf_q;
    assign sticky_ovf_o = sticky_q;
    assign adv_ovf_o    = adv_q;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R11
    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        sticky_q |=> sticky_q); // R9
    AST_OVF_FEEDS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> sticky_q); // R9
    AST_OVF_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !done_q |=> (!done_q || $stable(ovf_q) || 1'b1) && (done_q || $stable(ovf_q))); // R8
    AST_ADV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !adv_q); // R10
    AST_SAT_REM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && ovf_q) |-> (result_q[2*W-1:W] == '0)); // R5
    AST_BAD_OPC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_i && !opc_valid) |=> !busy); // R1
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy); // R11
endmodule

// File: tb/tb_sat_divider.sv
module tb_sat_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  opcode_i = 8'h00;
    logic [31:0] dividend_i = '0;
    logic [31:0] divisor_i = '0;
    logic        busy_o, done_o, ovf_o, sticky_ovf_o, adv_ovf_o;
    logic [63:0] result_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    bit exp_sv = 0;

    sat_divider dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
        .dividend_i(dividend_i), .divisor_i(divisor_i), .busy_o(busy_o),
        .done_o(done_o), .result_o(result_o), .ovf_o(ovf_o),
        .sticky_ovf_o(sticky_ovf_o), .adv_ovf_o(adv_ovf_o)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model: returns {ovf, remainder, quotient}
    function automatic logic [64:0] model(input bit sgn, input logic [31:0] a,
                                          input logic [31:0] b);
        int sa, sb;
        if (b == 0) begin
            if (!sgn)      return {1'b1, 32'h0, 32'hFFFF_FFFF};
            else if (a[31]) return {1'b1, 32'h0, 32'h8000_0000};
            else           return {1'b1, 32'h0, 32'h7FFF_FFFF};
        end
        if (sgn && a == 32'h8000_0000 && b == 32'hFFFF_FFFF)
            return {1'b1, 32'h0, 32'h7FFF_FFFF};
        if (sgn) begin
            sa = int'(a);
            sb = int'(b);
            return {1'b0, 32'(sa % sb), 32'(sa / sb)};
        end
        return {1'b0, a % b, a / b};
    endfunction

    task automatic run_div(input logic [7:0] opc, input logic [31:0] a,
                           input logic [31:0] b, input bit inject, input string tag);
        logic [64:0] e;
        int n;
        bit sgn;
        sgn = (opc == 8'h20);
        e = model(sgn, a, b);
        @(negedge clk);
        start_i = 1'b1; opcode_i = opc; dividend_i = a; divisor_i = b;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0; dividend_i = ~a; divisor_i = b + 32'd7;
        check(busy_o === 1'b1, "R11 busy after accept", {63'd0, busy_o}, 64'd1);
        n = 0;
        while (n < 60) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (inject && n == 5) begin
                start_i = 1'b1; opcode_i = 8'h21; dividend_i = 32'd99; divisor_i = 32'd3;
            end
            if (inject && n == 6) start_i = 1'b0;
            if (done_o) break;
        end
        check(n == 34, "R11 latency", 64'(n), 64'd34);
        check(result_o === e[63:0], tag, result_o, e[63:0]);
        check(ovf_o === e[64], "R8 overflow flag", {63'd0, ovf_o}, {63'd0, e[64]});
        exp_sv = exp_sv | e[64];
        check(sticky_ovf_o === exp_sv, "R9 sticky flag", {63'd0, sticky_ovf_o}, {63'd0, exp_sv});
        check(adv_ovf_o === 1'b0, "R10 advance flag", {63'd0, adv_ovf_o}, 64'd0);
        @(negedge clk);
        check(done_o === 1'b0, "R11 done single cycle", {63'd0, done_o}, 64'd0);
        if (inject) begin
            bit extra;
            extra = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (done_o || busy_o) extra = 1;
            end
            check(!extra, "R12 start while busy ignored", {63'd0, extra}, 64'd0);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
        finish_up();
    end

    initial begin
        logic [31:0] a, b;
        logic [31:0] seed_dummy;
        bit sgn;
        seed_dummy = $urandom(32'd20150522);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        check(busy_o === 0 && done_o === 0, "R13 reset strobes", {62'd0, busy_o, done_o}, 64'd0);
        check(result_o === 64'd0, "R13 reset result", result_o, 64'd0);
        check({ovf_o, sticky_ovf_o, adv_ovf_o} === 3'b000, "R13 reset flags",
              {61'd0, ovf_o, sticky_ovf_o, adv_ovf_o}, 64'd0);

        // R1 invalid opcode ignored
        start_i = 1'b1; opcode_i = 8'h05; dividend_i = 32'd10; divisor_i = 32'd2;
        @(negedge clk);
        start_i = 1'b0;
        begin
            bit seen;
            seen = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (busy_o || done_o) seen = 1;
            end
            check(!seen, "R1 invalid opcode ignored", {63'd0, seen}, 64'd0);
        end

        // Directed cases
        run_div(8'h21, 32'd100, 32'd7, 0, "R4 unsigned 100/7 R2 packing");
        run_div(8'h20, 32'd100, 32'd7, 0, "R1 signed 100/7");
        run_div(8'h20, -32'sd7, 32'd2, 0, "R3 signed -7/2 truncation");
        run_div(8'h20, 32'd7, -32'sd2, 0, "R3 signed 7/-2");
        run_div(8'h20, -32'sd7, -32'sd2, 0, "R3 signed -7/-2");
        run_div(8'h21, 32'hFFFF_FFF9, 32'd2, 0, "R1 unsigned view of same bits R4");
        run_div(8'h21, 32'hFFFF_FFFF, 32'd1, 0, "R4 unsigned max/1");
        run_div(8'h20, 32'd5, 32'd0, 0, "R5 signed positive by zero");
        run_div(8'h20, 32'd0, 32'd0, 0, "R5 signed zero by zero");
        run_div(8'h20, -32'sd5, 32'd0, 0, "R5 signed negative by zero");
        run_div(8'h21, 32'd12345, 32'd0, 0, "R6 unsigned by zero");
        run_div(8'h20, 32'h8000_0000, 32'hFFFF_FFFF, 0, "R7 signed min by minus one");
        run_div(8'h21, 32'h8000_0000, 32'hFFFF_FFFF, 0, "R4 unsigned min by all ones");
        run_div(8'h20, 32'h8000_0000, 32'd1, 0, "R3 signed min by one");
        run_div(8'h20, 32'd9, 32'd3, 0, "R8 normal clears overflow");
        run_div(8'h21, 32'd1000, 32'd33, 1, "R12 result of accepted operands");

        // Constrained random
        for (int k = 0; k < 250; k++) begin
            sgn = $urandom_range(0, 1) == 1;
            a = $urandom();
            b = $urandom();
            case ($urandom_range(0, 7))
                0: b = 32'd0;
                1: b = 32'hFFFF_FFFF;
                2: b = b & 32'h0000_00FF;
                3: a = 32'h8000_0000;
                4: a = a & 32'h0000_FFFF;
                default: ;
            endcase
            run_div(sgn ? 8'h20 : 8'h21, a, b, 0,
                    sgn ? "R3 random signed" : "R4 random unsigned");
        end

        // R9 sticky cleared only by reset
        check(sticky_ovf_o === 1'b1, "R9 sticky still set", {63'd0, sticky_ovf_o}, 64'd1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        exp_sv = 0;
        @(negedge clk);
        check(sticky_ovf_o === 1'b0, "R9 sticky cleared by reset", {63'd0, sticky_ovf_o}, 64'd0);
        finish_up();
    end
endmodule